// File: doc/BRIEF.md
# Scan-Mode Address Sequencer

This block produces the crate, slot and subaddress for a branch controller that walks a range of remote module addresses without processor help. A control word is loaded once. It carries the starting address, a function code, a data-width bit and five mode flags. After that, each completed remote operation is reported with a single step pulse, together with that operation's Q and X responses. On each step the block moves the address to its next value, or it raises a done indication, which serves as the branch's look-at-me signal.

The three address fields form a nested counter with the subaddress innermost, the slot in the middle and the crate outermost. Only the fields whose flags are set take part in the walk. A field that runs past its last value restarts at its first value and carries into the next enabled field. The walk ends when every enabled field is at its last value and one more step arrives. Two further flags allow a walk to stop early on a missing Q or a missing X. With no walk flag set, the block completes a single operation and then reports done.

Top module: `scan_addr_seq`

## Requirements
- R1: After reset, all address outputs are 0 and done is 0. A step pulse given before any control word has been loaded changes nothing.
- R2: A load pulse puts ld_crate, ld_slot, ld_sub, ld_func and ld_wide on the matching outputs one cycle later, and clears done.
- R3: ld_flags bit 0 enables the subaddress walk and bit 1 enables the slot walk. Bit 2 enables the crate walk. Bit 3 ends the walk on a missing Q, and bit 4 ends it on a missing X.
- R4: With only bit 0 set, each step raises sub by one while crate and slot stay fixed. The step taken at sub = 15 sets done and leaves the address unchanged.
- R5: With only bit 1 set, each step raises slot by one. The step taken at slot = 23 sets done.
- R6: With only bit 2 set, each step raises crate by one. The step taken at crate = 15 sets done.
- R7: When more than one walk flag is set, the walk nests with sub innermost, then slot, then crate. A field that wraps restarts at its first value (sub 0, slot 1, crate 0) and carries into the next enabled field. Done is set by the step taken when every enabled field is at its last value.
- R8: With no walk flag set, the first step after a load sets done and leaves the address unchanged.
- R9: When bit 3 is set, a step with q_ok = 0 sets done and leaves the address unchanged. Bit 4 works the same way with x_ok. When a flag is clear, the matching response is ignored and the walk goes on.
- R10: While done is 1, step pulses change neither the address nor done, until the next load.
- R11: If load and step arrive in the same cycle, the load takes effect and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load the control word |
| ld_crate | input | 4 | Starting crate |
| ld_slot | input | 5 | Starting slot |
| ld_sub | input | 4 | Starting subaddress |
| ld_func | input | 5 | Function code, passed through |
| ld_wide | input | 1 | Data width bit (0 = 16-bit, 1 = 24-bit), passed through |
| ld_flags | input | 5 | Mode flags, as described in R3 |
| step | input | 1 | The current operation has completed |
| q_ok | input | 1 | Q response of the completed operation |
| x_ok | input | 1 | X response of the completed operation |
| crate | output | 4 | Current crate |
| slot | output | 5 | Current slot |
| sub | output | 4 | Current subaddress |
| func | output | 5 | Loaded function code |
| wide | output | 1 | Loaded data width bit |
| done | output | 1 | Walk finished; look-at-me indication |

## Verification
Each of the seven walk-flag combinations is loaded from the lowest starting address, and every step of the walk is followed to its end. This covers every wrap and carry path, so a field restarting at the wrong value, a wrong nesting order or an early or late end all show up. A nested walk started close to its end checks how the block treats a start position that is not at the minimum. Patterns with Q and X missing, tried once with the matching flag set and once with it clear, distinguish early termination from ignored responses. A load and a step in the same cycle, and steps given after done, check which input takes priority.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    localparam int CRATE_W    = 4;
    localparam int SLOT_W     = 5;
    localparam int SUB_W      = 4;
    localparam int FUNC_W     = 5;
    localparam int FLAG_W     = 5;

    localparam int CRATE_LAST = 15;
    localparam int SLOT_FIRST = 1;
    localparam int SLOT_LAST  = 23;
    localparam int SUB_LAST   = 15;

    // bit 0 = walk_sub ... bit 4 = stop_no_x
    typedef struct packed {
        logic stop_no_x;
        logic stop_no_q;
        logic walk_crate;
        logic walk_slot;
        logic walk_sub;
    } scan_flags_t;

    function automatic logic any_walk(input scan_flags_t f);
        return f.walk_sub | f.walk_slot | f.walk_crate;
    endfunction

    function automatic logic resp_missed(input scan_flags_t f, input logic q, input logic x);
        return (f.stop_no_q & ~q) | (f.stop_no_x & ~x);
    endfunction

endpackage

// File: rtl/scan_field.sv
module scan_field #(
    parameter int W     = 4,
    parameter int FIRST = 0,
    parameter int LAST  = 15
) (
    input  logic [W-1:0] cur,
    input  logic         walk,
    input  logic         carry_in,
    output logic [W-1:0] nxt,
    output logic         carry_out
);
    localparam logic [W-1:0] FIRST_V = W'(FIRST);
    localparam logic [W-1:0] LAST_V  = W'(LAST);

    always_comb begin
        nxt       = cur;
        carry_out = carry_in;
        if (walk) begin
            carry_out = 1'b0;
            if (carry_in) begin
                if (cur >= LAST_V) begin
                    nxt       = FIRST_V;
                    carry_out = 1'b1;
                end else begin
                    nxt = cur + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/scan_term.sv
module scan_term
    import scan_seq_pkg::*;
(
    input  scan_flags_t flags,
    input  logic        q_ok,
    input  logic        x_ok,
    input  logic        wrap_out,
    output logic        finish,
    output logic        hold_addr
);
    always_comb begin
        hold_addr = resp_missed(flags, q_ok, x_ok) | ~any_walk(flags) | wrap_out;
        finish    = hold_addr;
    end
endmodule

// File: rtl/scan_addr_seq.sv
module scan_addr_seq
    import scan_seq_pkg::*;
#(
    parameter int C_W     = CRATE_W,
    parameter int N_W     = SLOT_W,
    parameter int A_W     = SUB_W,
    parameter int F_W     = FUNC_W,
    parameter int C_LAST  = CRATE_LAST,
    parameter int N_FIRST = SLOT_FIRST,
    parameter int N_LAST  = SLOT_LAST,
    parameter int A_LAST  = SUB_LAST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [C_W-1:0]    ld_crate,
    input  logic [N_W-1:0]    ld_slot,
    input  logic [A_W-1:0]    ld_sub,
    input  logic [F_W-1:0]    ld_func,
    input  logic              ld_wide,
    input  logic [FLAG_W-1:0] ld_flags,
    input  logic              step,
    input  logic              q_ok,
    input  logic              x_ok,
    output logic [C_W-1:0]    crate,
    output logic [N_W-1:0]    slot,
    output logic [A_W-1:0]    sub,
    output logic [F_W-1:0]    func,
    output logic              wide,
    output logic              done
);
    logic [C_W-1:0] crate_q, crate_n;
    logic [N_W-1:0] slot_q,  slot_n;
    logic [A_W-1:0] sub_q,   sub_n;
    logic [F_W-1:0] func_q;
    logic           wide_q;
    scan_flags_t    flags_q;
    logic           armed_q, done_q;
    logic           c_sub, c_slot, c_crate;
    logic           finish, hold_addr, adv;

    scan_field #(.W(A_W), .FIRST(0), .LAST(A_LAST)) u_sub (
        .cur(sub_q), .walk(flags_q.walk_sub), .carry_in(1'b1),
        .nxt(sub_n), .carry_out(c_sub)
    );
    scan_field #(.W(N_W), .FIRST(N_FIRST), .LAST(N_LAST)) u_slot (
        .cur(slot_q), .walk(flags_q.walk_slot), .carry_in(c_sub),
        .nxt(slot_n), .carry_out(c_slot)
    );
    scan_field #(.W(C_W), .FIRST(0), .LAST(C_LAST)) u_crate (
        .cur(crate_q), .walk(flags_q.walk_crate), .carry_in(c_slot),
        .nxt(crate_n), .carry_out(c_crate)
    );

    scan_term u_term (
        .flags(flags_q), .q_ok(q_ok), .x_ok(x_ok), .wrap_out(c_crate),
        .finish(finish), .hold_addr(hold_addr)
    );

    assign adv = step & armed_q & ~done_q & ~load;

    always_ff @(posedge clk) begin
        if (rst) begin
            crate_q <= '0;
            slot_q  <= '0;
            sub_q   <= '0;
            func_q  <= '0;
            wide_q  <= 1'b0;
            flags_q <= '0;
            armed_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (load) begin
            crate_q <= ld_crate;
            slot_q  <= ld_slot;
            sub_q   <= ld_sub;
            func_q  <= ld_func;
            wide_q  <= ld_wide;
            flags_q <= scan_flags_t'(ld_flags);
            armed_q <= 1'b1;
            done_q  <= 1'b0;
        end else if (adv) begin
            if (finish) done_q <= 1'b1;
            if (!hold_addr) begin
                crate_q <= crate_n;
                slot_q  <= slot_n;
                sub_q   <= sub_n;
            end
        end
    end

    assign crate = crate_q;
    assign slot  = slot_q;
    assign sub   = sub_q;
    assign func  = func_q;
    assign wide  = wide_q;
    assign done  = done_q;
endmodule

// File: rtl/scan_addr_seq_chk.sv
module scan_addr_seq_chk
    import scan_seq_pkg::*;
#(
    parameter int C_W    = CRATE_W,
    parameter int N_W    = SLOT_W,
    parameter int A_W    = SUB_W,
    parameter int A_LAST = SUB_LAST
) (
    input logic           clk,
    input logic           rst,
    input logic           load,
    input logic           step,
    input logic           q_ok,
    input logic           x_ok,
    input logic [C_W-1:0] ld_crate,
    input logic [N_W-1:0] ld_slot,
    input logic [A_W-1:0] ld_sub,
    input logic [C_W-1:0] crate,
    input logic [N_W-1:0] slot,
    input logic [A_W-1:0] sub,
    input logic           done,
    input logic           armed,
    input scan_flags_t    flags
);
    logic adv, miss;
    assign adv  = step & armed & ~done & ~load;
    assign miss = (flags.stop_no_q & ~q_ok) | (flags.stop_no_x & ~x_ok);

    // R2
    load_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !done);

    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (crate == $past(ld_crate) && slot == $past(ld_slot) && sub == $past(ld_sub)));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> (done && $stable(crate) && $stable(slot) && $stable(sub)));

    // R1
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> ($stable(crate) && $stable(slot) && $stable(sub) && $stable(done)));

    // R9
    missed_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && miss) |=> (done && $stable(crate) && $stable(slot) && $stable(sub)));

    // R8
    single_op_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !flags.walk_sub && !flags.walk_slot && !flags.walk_crate) |=> done);

    // R4
    sub_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !miss && flags.walk_sub && sub < A_W'(A_LAST)) |=> (sub == $past(sub) + 1'b1 && !done));
endmodule

bind scan_addr_seq scan_addr_seq_chk #(
    .C_W(C_W), .N_W(N_W), .A_W(A_W), .A_LAST(A_LAST)
) u_chk (
    .clk(clk), .rst(rst), .load(load), .step(step), .q_ok(q_ok), .x_ok(x_ok),
    .ld_crate(ld_crate), .ld_slot(ld_slot), .ld_sub(ld_sub),
    .crate(crate), .slot(slot), .sub(sub), .done(done),
    .armed(armed_q), .flags(flags_q)
);

// File: tb/scan_addr_seq_test.sv
`timescale 1ns/1ps
module scan_addr_seq_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0, step = 1'b0, q_ok = 1'b1, x_ok = 1'b1;
    logic [3:0] ld_crate = '0, ld_sub = '0;
    logic [4:0] ld_slot = '0, ld_func = '0, ld_flags = '0;
    logic       ld_wide = 1'b0;
    logic [3:0] crate, sub;
    logic [4:0] slot, func;
    logic       wide, done;

    int errs = 0, checks = 0;
    logic [3:0] e_c = '0, e_a = '0;
    logic [4:0] e_n = '0, e_f = '0;
    logic       e_done = 1'b0, e_armed = 1'b0;

    always #4 clk = ~clk;

    scan_addr_seq uut (
        .clk(clk), .rst(rst), .load(load), .ld_crate(ld_crate), .ld_slot(ld_slot),
        .ld_sub(ld_sub), .ld_func(ld_func), .ld_wide(ld_wide), .ld_flags(ld_flags),
        .step(step), .q_ok(q_ok), .x_ok(x_ok), .crate(crate), .slot(slot), .sub(sub),
        .func(func), .wide(wide), .done(done)
    );

    task automatic check(input string tag);
        checks++;
        if (crate !== e_c || slot !== e_n || sub !== e_a || done !== e_done) begin
            errs++;
            $display("FAIL %s: got c=%0d n=%0d a=%0d done=%0b exp c=%0d n=%0d a=%0d done=%0b",
                     tag, crate, slot, sub, done, e_c, e_n, e_a, e_done);
        end
    endtask

    task automatic model(input logic q, input logic x);
        logic       carry;
        logic [3:0] na, nc;
        logic [4:0] nn;
        if (!e_armed || e_done) return;
        if ((e_f[3] && !q) || (e_f[4] && !x) || e_f[2:0] == 3'b000) begin
            e_done = 1'b1;
            return;
        end
        carry = 1'b1; na = e_a; nn = e_n; nc = e_c;
        if (e_f[0]) begin
            if (e_a == 4'd15) na = 4'd0; else begin na = e_a + 4'd1; carry = 1'b0; end
        end
        if (e_f[1] && carry) begin
            if (e_n >= 5'd23) nn = 5'd1; else begin nn = e_n + 5'd1; carry = 1'b0; end
        end
        if (e_f[2] && carry) begin
            if (e_c == 4'd15) nc = 4'd0; else begin nc = e_c + 4'd1; carry = 1'b0; end
        end
        if (carry) e_done = 1'b1;
        else begin e_a = na; e_n = nn; e_c = nc; end
    endtask

    task automatic do_load(input logic [3:0] c, input logic [4:0] n, input logic [3:0] a,
                           input logic [4:0] f, input logic [4:0] fn, input logic w,
                           input logic with_step, input string tag);
        @(negedge clk);
        load = 1'b1; step = with_step;
        ld_crate = c; ld_slot = n; ld_sub = a; ld_flags = f; ld_func = fn; ld_wide = w;
        @(negedge clk);
        load = 1'b0; step = 1'b0;
        e_c = c; e_n = n; e_a = a; e_f = f; e_done = 1'b0; e_armed = 1'b1;
        check(tag);
        checks++;
        if (func !== fn || wide !== w) begin
            errs++;
            $display("FAIL %s: got func=%0d wide=%0b exp func=%0d wide=%0b", tag, func, wide, fn, w);
        end
    endtask

    task automatic do_step(input logic q, input logic x, input string tag);
        @(negedge clk);
        step = 1'b1; q_ok = q; x_ok = x;
        @(negedge clk);
        step = 1'b0; q_ok = 1'b1; x_ok = 1'b1;
        model(q, x);
        check(tag);
    endtask

    initial begin
        #(200000 * 8);
        errs++;
        $display("FAIL watchdog: got running exp finished");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset");
        do_step(1'b0, 1'b0, "R1 step before load");

        // R2, R8, R10: no walk flags
        do_load(4'd3, 5'd7, 4'd2, 5'b00000, 5'd9, 1'b1, 1'b0, "R2 load");
        do_step(1'b1, 1'b1, "R8 single op");
        do_step(1'b1, 1'b1, "R10 step after done");

        // R3..R7: every walk combination, full sweep
        for (int m = 1; m < 8; m++) begin
            tag = (m == 1) ? "R4 sub walk" : (m == 2) ? "R5 slot walk" :
                  (m == 4) ? "R6 crate walk" : "R7 nested walk";
            do_load(4'd0, 5'd1, 4'd0, 5'(m), 5'd16, 1'b0, 1'b0, "R3 load");
            for (int k = 0; k < 7000 && !e_done; k++) do_step(1'b1, 1'b1, tag);
            do_step(1'b1, 1'b1, "R10 hold after walk");
        end

        // R7: nested walk from a start near its end
        do_load(4'd14, 5'd22, 4'd13, 5'b00111, 5'd1, 1'b1, 1'b0, "R7 late start");
        for (int k = 0; k < 200 && !e_done; k++) do_step(1'b1, 1'b1, "R7 late walk");

        // R9: missing Q with flag set
        do_load(4'd5, 5'd4, 4'd6, 5'b01001, 5'd0, 1'b0, 1'b0, "R9 load q");
        do_step(1'b1, 1'b0, "R9 q ok");
        do_step(1'b1, 1'b1, "R9 q ok 2");
        do_step(1'b0, 1'b1, "R9 q missing");
        do_step(1'b1, 1'b1, "R10 after q stop");
        // R9: missing X with flag set
        do_load(4'd5, 5'd4, 4'd6, 5'b10010, 5'd0, 1'b0, 1'b0, "R9 load x");
        do_step(1'b0, 1'b1, "R9 x ok");
        do_step(1'b1, 1'b0, "R9 x missing");
        // R9: flags clear, responses ignored
        do_load(4'd2, 5'd2, 4'd2, 5'b00001, 5'd0, 1'b0, 1'b0, "R9 load ign");
        do_step(1'b0, 1'b0, "R9 ignored q x");
        do_step(1'b0, 1'b0, "R9 ignored q x 2");

        // R11: load and step together
        do_load(4'd8, 5'd9, 4'd10, 5'b00001, 5'd3, 1'b1, 1'b1, "R11 load wins");
        do_step(1'b1, 1'b1, "R11 first step");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule